// File: doc/BRIEF.md
# Single-Cell Charge Cycle Sequencer

This block is the digital controller that walks a one-cell lithium battery through its charge cycle. It reads qualifier flags produced by analog comparators elsewhere (input power good, an active-low enable, three battery-voltage comparisons, a tapered-current flag, an over-voltage flag, a temperature-window flag and a battery-presence flag). From these it selects how the power stage runs: off, linear low-current precharge, switching constant-current or switching constant-voltage. Two status bits report the cycle's condition, and can drive indicator lights or be read by a host.

Safety limits are measured in periods of an external slow oscillator, which arrives as a one-clock tick pulse. A saturating tick counter limits the time spent in precharge to 2^PRE_LOG2 ticks and the time spent in constant-current plus constant-voltage charging to 2^FULL_LOG2 ticks. A strap input turns both limits off. Any over-voltage or timeout latches a fault. Only the loss of input power or a high pulse on the enable clears it.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While in reset, while power-good is low or while the enable input is high, the status pair {stat1,stat2} reads 2'b11 and mode reads 2'b00 (power stage off) one clock after the condition is sampled.
- R2: A new cycle always starts in precharge. Status reads 2'b00 and mode reads 2'b01 (linear) one clock after a qualified start while the battery is below the precharge threshold.
- R3: Precharge moves to constant-current (mode 2'b10) when the above-precharge flag is set. Constant-current moves to constant-voltage (mode 2'b11) when the final-voltage flag is set. Status stays 2'b00 in all three charging modes.
- R4: If 2^PRE_LOG2 oscillator ticks are counted in precharge, the block enters fault (status 2'b10, mode 2'b00).
- R5: The fast-charge limit counts ticks from entry into constant-current through constant-voltage. After 2^FULL_LOG2 ticks the block enters fault. Ticks counted in precharge do not count toward this limit.
- R6: The over-voltage flag, seen in any charging mode or in complete, forces fault on the next clock.
- R7: Fault holds while power-good stays high and enable stays low. This is true whatever the battery, temperature, voltage and current flags do.
- R8: Termination needs the tapered-current flag to be held high in constant-voltage through EOC_TICKS ticks. A low sample restarts the count. Once the count completes, status reads 2'b01 and mode reads 2'b00.
- R9: In complete, the below-recharge flag moves the block into constant-current with the safety counter cleared to zero.
- R10: A temperature-out-of-window flag in any charging mode gives status 2'b11 and mode 2'b00. When the temperature returns to the window, a new cycle starts in precharge with the counter cleared.
- R11: With timer_off high, neither timeout ever fires.
- R12: Each of these starts a new cycle: enable falling, a battery being inserted, or power-good returning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| pwr_good | input | 1 | Input supply qualified |
| en_n | input | 1 | Charger enable, active low |
| vbat_above_pre | input | 1 | Battery above precharge threshold |
| vbat_at_final | input | 1 | Battery at final regulation voltage |
| vbat_below_rechg | input | 1 | Battery below recharge threshold |
| eoc_flag | input | 1 | Charge current below termination level (raw) |
| ovp_flag | input | 1 | Battery over-voltage |
| temp_ok | input | 1 | Thermistor reading inside the allowed window |
| batt_present | input | 1 | Battery detected |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| timer_off | input | 1 | Strap disabling both safety timeouts |
| mode | output | 2 | Power stage select: 00 off, 01 linear, 10 switching CC, 11 switching CV |
| stat1 | output | 1 | Status bit 1 (first bit of the pair) |
| stat2 | output | 1 | Status bit 2 (second bit of the pair) |

## Verification
A corrupted state register appears on the mode and status pins on the clock after the edge that loaded it, because both are decoded directly from the registered state. A counter that misses or double-counts ticks, or that is not cleared on entry to constant-current, recharge or recovery, shows up as a fault code that arrives one tick early or late. The bench therefore probes one tick before each limit and on the limit itself. A deglitch filter that fails to restart shows up as a premature complete code, so the bench breaks the tapered-current flag in the middle of its count.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TRICKLE = 3'd1,
        ST_CC      = 3'd2,
        ST_CV      = 3'd3,
        ST_DONE    = 3'd4,
        ST_SUSP    = 3'd5,
        ST_FAULT   = 3'd6
    } chg_st_e;

    typedef enum logic [1:0] {
        PWR_OFF    = 2'b00,
        PWR_LINEAR = 2'b01,
        PWR_SW_CC  = 2'b10,
        PWR_SW_CV  = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        chg_st_e st;
    } ctl_s;

endpackage

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
    parameter int FULL_LOG2 = 22,
    parameter int PRE_LOG2  = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic pre_exp_o,
    output logic full_exp_o
);
    localparam int CNT_W = FULL_LOG2 + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Saturates once the top bit is set so the limit stays visible.
    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (run_i && tick_i && !cnt_q[FULL_LOG2])
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pre_exp_o  = |cnt_q[FULL_LOG2:PRE_LOG2];
    assign full_exp_o = cnt_q[FULL_LOG2];

endmodule

// File: rtl/chg_eoc_filter.sv
module chg_eoc_filter #(
    parameter int EOC_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic flag_i,
    input  logic tick_i,
    output logic ok_o
);
    localparam int W = $clog2(EOC_TICKS + 1);
    localparam logic [W-1:0] LIM = W'(EOC_TICKS);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i || !flag_i)
            cnt_d = '0;
        else if (tick_i && cnt_q != LIM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ok_o = (cnt_q == LIM);

endmodule

// File: rtl/chg_status_enc.sv
module chg_status_enc
    import chg_seq_pkg::*;
(
    input  chg_st_e    st_i,
    output logic       stat1_o,
    output logic       stat2_o,
    output logic [1:0] mode_o
);
    logic [1:0] pair;

    always_comb begin
        pair   = 2'b11;
        mode_o = PWR_OFF;
        case (st_i)
            ST_TRICKLE: begin pair = 2'b00; mode_o = PWR_LINEAR; end
            ST_CC:      begin pair = 2'b00; mode_o = PWR_SW_CC;  end
            ST_CV:      begin pair = 2'b00; mode_o = PWR_SW_CV;  end
            ST_DONE:    pair = 2'b01;
            ST_FAULT:   pair = 2'b10;
            default:    pair = 2'b11;
        endcase
    end

    assign stat1_o = pair[1];
    assign stat2_o = pair[0];

endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int FULL_LOG2 = 22,
    parameter int PRE_LOG2  = 19,
    parameter int EOC_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       en_n,
    input  logic       vbat_above_pre,
    input  logic       vbat_at_final,
    input  logic       vbat_below_rechg,
    input  logic       eoc_flag,
    input  logic       ovp_flag,
    input  logic       temp_ok,
    input  logic       batt_present,
    input  logic       osc_tick,
    input  logic       timer_off,
    output logic [1:0] mode,
    output logic       stat1,
    output logic       stat2
);
    ctl_s ctl_d, ctl_q;

    logic pre_exp, full_exp, eoc_ok;
    logic pre_to, full_to;
    logic tmr_clear, tmr_run;

    assign pre_to  = pre_exp  && !timer_off;
    assign full_to = full_exp && !timer_off;

    always_comb begin
        ctl_d = ctl_q;
        if (!pwr_good || en_n) begin
            ctl_d.st = ST_IDLE;
        end else if (ctl_q.st == ST_FAULT) begin
            ctl_d.st = ST_FAULT;
        end else if (!batt_present) begin
            ctl_d.st = ST_IDLE;
        end else begin
            case (ctl_q.st)
                ST_IDLE:  ctl_d.st = temp_ok ? ST_TRICKLE : ST_SUSP;
                ST_SUSP:  if (temp_ok) ctl_d.st = ST_TRICKLE;
                ST_DONE: begin
                    if (ovp_flag)              ctl_d.st = ST_FAULT;
                    else if (vbat_below_rechg) ctl_d.st = ST_CC;
                end
                ST_TRICKLE, ST_CC, ST_CV: begin
                    if (ovp_flag)      ctl_d.st = ST_FAULT;
                    else if (!temp_ok) ctl_d.st = ST_SUSP;
                    else if (ctl_q.st == ST_TRICKLE) begin
                        if (vbat_above_pre) ctl_d.st = ST_CC;
                        else if (pre_to)    ctl_d.st = ST_FAULT;
                    end else if (ctl_q.st == ST_CC) begin
                        if (full_to)            ctl_d.st = ST_FAULT;
                        else if (vbat_at_final) ctl_d.st = ST_CV;
                    end else begin
                        if (eoc_ok)       ctl_d.st = ST_DONE;
                        else if (full_to) ctl_d.st = ST_FAULT;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.st <= ST_IDLE;
        else        ctl_q    <= ctl_d;
    end

    assign tmr_clear = (ctl_d.st == ST_TRICKLE && ctl_q.st != ST_TRICKLE) ||
                       (ctl_d.st == ST_CC      && ctl_q.st != ST_CC);
    assign tmr_run   = (ctl_q.st == ST_TRICKLE) || (ctl_q.st == ST_CC) ||
                       (ctl_q.st == ST_CV);

    chg_safety_timer #(
        .FULL_LOG2 (FULL_LOG2),
        .PRE_LOG2  (PRE_LOG2)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (tmr_clear),
        .run_i      (tmr_run),
        .tick_i     (osc_tick),
        .pre_exp_o  (pre_exp),
        .full_exp_o (full_exp)
    );

    chg_eoc_filter #(
        .EOC_TICKS (EOC_TICKS)
    ) u_eoc (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (ctl_q.st == ST_CV),
        .flag_i (eoc_flag),
        .tick_i (osc_tick),
        .ok_o   (eoc_ok)
    );

    chg_status_enc u_enc (
        .st_i    (ctl_q.st),
        .stat1_o (stat1),
        .stat2_o (stat2),
        .mode_o  (mode)
    );

endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       en_n,
    input logic       batt_present,
    input logic       ovp_flag,
    input logic       temp_ok,
    input logic       vbat_below_rechg,
    input logic [1:0] mode,
    input logic       stat1,
    input logic       stat2
);
    logic [1:0] st_pair;
    assign st_pair = {stat1, stat2};

    assert_disabled_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good || en_n) |=> (st_pair == 2'b11 && mode == 2'b00));

    assert_cv_after_cc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> ($past(mode) == 2'b10 || $past(mode) == 2'b11));

    assert_ovp_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && pwr_good && !en_n && batt_present && ovp_flag)
        |=> (st_pair == 2'b10));

    assert_fault_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pair == 2'b10 && pwr_good && !en_n) |=> (st_pair == 2'b10));

    assert_recharge_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pair == 2'b01 && pwr_good && !en_n && batt_present && !ovp_flag &&
         vbat_below_rechg) |=> (mode == 2'b10));

    assert_restart_trickle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pair == 2'b11 && pwr_good && !en_n && batt_present && temp_ok)
        |=> (mode == 2'b01));

endmodule

bind chg_seq_ctrl chg_seq_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pwr_good         (pwr_good),
    .en_n             (en_n),
    .batt_present     (batt_present),
    .ovp_flag         (ovp_flag),
    .temp_ok          (temp_ok),
    .vbat_below_rechg (vbat_below_rechg),
    .mode             (mode),
    .stat1            (stat1),
    .stat2            (stat2)
);

// File: tb/chg_seq_ctrl_bench.sv
`timescale 1ns/1ps
module chg_seq_ctrl_bench;
    localparam logic [1:0] M_OFF = 2'b00, M_LIN = 2'b01, M_CC = 2'b10, M_CV = 2'b11;
    localparam logic [1:0] S_RUN = 2'b00, S_DONE = 2'b01, S_FLT = 2'b10, S_SUS = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1, en_n = 1'b1, vbat_above_pre = 1'b0, vbat_at_final = 1'b0;
    logic vbat_below_rechg = 1'b0, eoc_flag = 1'b0, ovp_flag = 1'b0, temp_ok = 1'b1;
    logic batt_present = 1'b1, osc_tick = 1'b0, timer_off = 1'b0;
    logic [1:0] mode;
    logic stat1, stat2;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [1:0] q_stat[$];
    logic [1:0] q_mode[$];
    string      q_tag[$];
    event       ev_push;

    always #2 clk = ~clk;

    chg_seq_ctrl #(.FULL_LOG2(6), .PRE_LOG2(3), .EOC_TICKS(3)) u_chg_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .en_n(en_n),
        .vbat_above_pre(vbat_above_pre), .vbat_at_final(vbat_at_final),
        .vbat_below_rechg(vbat_below_rechg), .eoc_flag(eoc_flag),
        .ovp_flag(ovp_flag), .temp_ok(temp_ok), .batt_present(batt_present),
        .osc_tick(osc_tick), .timer_off(timer_off),
        .mode(mode), .stat1(stat1), .stat2(stat2)
    );

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        forever begin
            @(ev_push);
            while (q_tag.size() > 0) begin
                logic [1:0] es, em;
                string t;
                es = q_stat.pop_front();
                em = q_mode.pop_front();
                t  = q_tag.pop_front();
                n_cmp++;
                if ({stat1, stat2} !== es || mode !== em) begin
                    n_bad++;
                    $display("FAIL %s: stat=%b mode=%b expected stat=%b mode=%b",
                             t, {stat1, stat2}, mode, es, em);
                end
            end
        end
    end

    task automatic expect_out(input logic [1:0] s, input logic [1:0] m, input string t);
        q_stat.push_back(s);
        q_mode.push_back(m);
        q_tag.push_back(t);
        -> ev_push;
        #0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        expect_out(S_SUS, M_OFF, "R1 in reset");
        rst_n = 1'b1;
        step();
        expect_out(S_SUS, M_OFF, "R1 enable high");

        en_n = 1'b0; step();
        expect_out(S_RUN, M_LIN, "R2 enable low starts precharge");

        vbat_above_pre = 1'b1; step();
        expect_out(S_RUN, M_CC, "R3 precharge to CC");
        vbat_at_final = 1'b1; step();
        expect_out(S_RUN, M_CV, "R3 CC to CV");

        // Tapered current: broken after two ticks, then held for three.
        eoc_flag = 1'b1; tick_n(2);
        eoc_flag = 1'b0; step();
        eoc_flag = 1'b1; tick_n(2); step();
        expect_out(S_RUN, M_CV, "R8 restart after glitch");
        tick_n(1); step();
        expect_out(S_DONE, M_OFF, "R8 termination accepted");

        eoc_flag = 1'b0; vbat_at_final = 1'b0;
        vbat_below_rechg = 1'b1; step();
        expect_out(S_RUN, M_CC, "R9 recharge enters CC");
        vbat_below_rechg = 1'b0;
        tick_n(63); step();
        expect_out(S_RUN, M_CC, "R9 timer cleared on recharge");
        tick_n(1); step();
        expect_out(S_FLT, M_OFF, "R5 fast-charge timeout");

        batt_present = 1'b0; vbat_above_pre = 1'b0; temp_ok = 1'b0; tick_n(3); step();
        expect_out(S_FLT, M_OFF, "R7 fault held");
        batt_present = 1'b1; temp_ok = 1'b1;
        en_n = 1'b1; step();
        expect_out(S_SUS, M_OFF, "R7 enable high clears fault");
        en_n = 1'b0; step();
        expect_out(S_RUN, M_LIN, "R12 enable fall new cycle");

        tick_n(7); step();
        expect_out(S_RUN, M_LIN, "R4 one tick before precharge limit");
        tick_n(1); step();
        expect_out(S_FLT, M_OFF, "R4 precharge timeout");

        pwr_good = 1'b0; step();
        expect_out(S_SUS, M_OFF, "R1 power lost clears fault");
        pwr_good = 1'b1; step();
        expect_out(S_RUN, M_LIN, "R12 power return new cycle");

        vbat_above_pre = 1'b1; step();
        expect_out(S_RUN, M_CC, "R3 CC before overvoltage");
        ovp_flag = 1'b1; step();
        expect_out(S_FLT, M_OFF, "R6 overvoltage fault");
        ovp_flag = 1'b0; vbat_above_pre = 1'b0;
        en_n = 1'b1; step();
        en_n = 1'b0; step();
        expect_out(S_RUN, M_LIN, "R12 restart after overvoltage");

        tick_n(5);
        temp_ok = 1'b0; step();
        expect_out(S_SUS, M_OFF, "R10 suspend on temperature");
        tick_n(4);
        temp_ok = 1'b1; step();
        expect_out(S_RUN, M_LIN, "R10 recovery new cycle");
        tick_n(7); step();
        expect_out(S_RUN, M_LIN, "R10 timer cleared on recovery");

        timer_off = 1'b1;
        tick_n(20); step();
        expect_out(S_RUN, M_LIN, "R11 no precharge timeout");
        vbat_above_pre = 1'b1; step();
        expect_out(S_RUN, M_CC, "R11 enter CC");
        tick_n(70); step();
        expect_out(S_RUN, M_CC, "R11 no fast-charge timeout");
        timer_off = 1'b0;

        batt_present = 1'b0; step();
        expect_out(S_SUS, M_OFF, "R1 battery removed");
        batt_present = 1'b1; step();
        expect_out(S_RUN, M_LIN, "R12 insertion starts precharge");
        step();
        expect_out(S_RUN, M_CC, "R3 insertion then CC");

        step();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule